// File: doc/BRIEF.md
# Graded Power Mode Controller

This block is the power mode sequencer of a system-on-chip. Software writes a per-peripheral clock enable mask and a wake source mask through a small write port. A mode request input then moves the chip between five operating modes. ON runs everything at full speed. SLOW runs everything from a reduced clock. IDLE gates only the processor clock. STOP turns off every clock, the crystal oscillator and the PLL. SLEEP also switches off the internal logic supply, so that only the wake logic keeps running.

Leaving IDLE takes one cycle after an enabled wake event. Leaving STOP or SLEEP follows a fixed restart order. The supply and the oscillator come back first. After an oscillator start-up count the PLL is enabled. After the PLL reports lock, the lock has to stay up for a settle count before any clock is released. All outputs are registered and change on the clock edge that samples the input causing them.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is high and on the first edge after it, the mode is ON, every peripheral clock enable is 1, the wake mask is all zero, and the processor clock, oscillator, PLL and logic supply are on, with the slow select at 0.
- R2: A write with address 0 loads the peripheral clock enable mask and address 1 loads the wake mask. Other addresses are ignored. In ON, SLOW and IDLE, ip_clk_en equals the mask one edge after the write.
- R3: In ON (mode_state 0) the processor clock, oscillator, PLL and supply are on and slow_clk_sel is 0. In SLOW (mode_state 1) the same outputs are on and slow_clk_sel is 1.
- R4: In IDLE (mode_state 2), cpu_clk_en is 0. Peripheral clocks follow their mask, and the oscillator, PLL and supply stay on.
- R5: In STOP (mode_state 3), all peripheral clock enables, cpu_clk_en, osc_en and pll_en are 0, while logic_pwr_en stays 1. Mask writes made in STOP do not show up on ip_clk_en.
- R6: In SLEEP (mode_state 4), everything that is off in STOP is off, and logic_pwr_en is 0 as well.
- R7: A request with mode_req_vld high and code 0 to 4 (ON, SLOW, IDLE, STOP, SLEEP) is taken on the next edge, but only from ON or SLOW. Codes 5 to 7 are ignored. Requests are also ignored in IDLE, STOP, SLEEP and in all wake states.
- R8: In IDLE, a wake_evt bit that is set in the wake mask moves the mode to ON on the next edge. Wake bits that are not set in the mask are ignored. Wake events have no effect in ON or SLOW.
- R9: An enabled wake event in STOP or SLEEP enters the oscillator wait (mode_state 5). This state has osc_en and logic_pwr_en at 1 and pll_en at 0, and lasts OSC_CYC cycles. It then enters the lock wait (mode_state 6), with pll_en at 1.
- R10: When pll_lock is sampled high in the lock wait, the settle state (mode_state 7) is entered. After SETTLE_CYC cycles with lock held, the mode becomes ON. If lock drops during settle, the mode returns to the lock wait. All clock enables stay 0 in states 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | ADDR_W | Register select: 0 clock mask, 1 wake mask |
| cfg_wr_data | input | max(N_IP,N_WAKE) | Write data |
| mode_req_vld | input | 1 | Mode request strobe |
| mode_req_code | input | 3 | Requested mode code 0..4 |
| wake_evt | input | N_WAKE | Wake and interrupt event lines |
| pll_lock | input | 1 | PLL lock indication |
| ip_clk_en | output | N_IP | Per-peripheral clock enables |
| cpu_clk_en | output | 1 | Processor clock enable |
| slow_clk_sel | output | 1 | Selects the reduced clock |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| logic_pwr_en | output | 1 | Internal logic supply switch enable |
| mode_state | output | 3 | Current mode/phase code |

## Verification
Every internal state drives its own pattern on the six control outputs and on mode_state. A wrong next-state choice therefore shows at the ports on the edge where it is made. A wrong restart timer shows up differently: the oscillator wait ends early or late, and the shift in the pll_en rise reveals it within OSC_CYC cycles. A bad settle count shifts the release of the clocks by a matching number of cycles. A lost lock that is not handled leaves the clocks released while pll_lock is low.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_ON     = 3'd0,
    PM_SLOW   = 3'd1,
    PM_IDLE   = 3'd2,
    PM_STOP   = 3'd3,
    PM_SLEEP  = 3'd4,
    PM_WK_OSC = 3'd5,
    PM_WK_PLL = 3'd6,
    PM_WK_SET = 3'd7
  } pm_state_e;

  localparam logic [2:0] REQ_MAX = 3'd4;

  typedef struct packed {
    logic clk_on;   // peripheral clocks may run
    logic cpu;
    logic slow;
    logic osc;
    logic pll;
    logic pwr;
  } pm_ctl_t;

  function automatic pm_ctl_t pm_decode(input pm_state_e s);
    pm_ctl_t c;
    c = '{clk_on: 1'b0, cpu: 1'b0, slow: 1'b0, osc: 1'b0, pll: 1'b0, pwr: 1'b1};
    case (s)
      PM_ON:     c = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
      PM_SLOW:   c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
      PM_IDLE:   c = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
      PM_STOP:   c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      PM_SLEEP:  c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      PM_WK_OSC: c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
      PM_WK_PLL: c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
      PM_WK_SET: c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
      default:   c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs #(
  parameter int N_IP   = 8,
  parameter int N_WAKE = 4,
  parameter int ADDR_W = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_IP-1:0]   ip_mask_q,
  output logic [N_IP-1:0]   ip_mask_d,
  output logic [N_WAKE-1:0] wake_mask_q
);

  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(1);

  logic hit_clk, hit_wake;
  logic unused_data;

  assign hit_clk     = wr_en && (wr_addr == A_CLK);
  assign hit_wake    = wr_en && (wr_addr == A_WAKE);
  assign unused_data = ^wr_data;

  always_comb begin
    ip_mask_d = ip_mask_q;
    if (hit_clk) ip_mask_d = wr_data[N_IP-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_mask_q   <= '1;
      wake_mask_q <= '0;
    end else begin
      ip_mask_q <= ip_mask_d;
      if (hit_wake) wake_mask_q <= wr_data[N_WAKE-1:0];
    end
  end

  // R2: a clock mask write lands in the register on the next edge
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
    hit_clk |=> (ip_mask_q == $past(wr_data[N_IP-1:0])));

endmodule

// File: rtl/pmc_timer.sv
module pmc_timer #(
  parameter int MAX_CYC = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [$clog2(MAX_CYC+1)-1:0] load_val,
  output logic                       zero
);

  localparam int CW = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  assert_count_down_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int N_WAKE     = 4,
  parameter int OSC_CYC    = 4,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [2:0]        req_code,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic [N_WAKE-1:0] wake_mask,
  input  logic              pll_lock,
  output pm_state_e         state_q,
  output pm_state_e         state_d
);

  localparam int MAX_CYC = (OSC_CYC > SETTLE_CYC) ? OSC_CYC : SETTLE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] OSC_LD = CW'(OSC_CYC - 1);
  localparam logic [CW-1:0] SET_LD = CW'(SETTLE_CYC - 1);

  logic          wake_hit;
  logic          req_ok;
  logic          t_load, t_zero;
  logic [CW-1:0] t_val;

  assign wake_hit = |(wake_evt & wake_mask);
  assign req_ok   = req_vld && (req_code <= REQ_MAX);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PM_ON, PM_SLOW: if (req_ok) state_d = pm_state_e'(req_code);
      PM_IDLE:        if (wake_hit) state_d = PM_ON;
      PM_STOP,
      PM_SLEEP:       if (wake_hit) state_d = PM_WK_OSC;
      PM_WK_OSC:      if (t_zero) state_d = PM_WK_PLL;
      PM_WK_PLL:      if (pll_lock) state_d = PM_WK_SET;
      PM_WK_SET: begin
        if (!pll_lock)   state_d = PM_WK_PLL;
        else if (t_zero) state_d = PM_ON;
      end
      default:        state_d = PM_ON;
    endcase
  end

  assign t_load = ((state_d == PM_WK_OSC) && (state_q != PM_WK_OSC)) ||
                  ((state_d == PM_WK_SET) && (state_q != PM_WK_SET));
  assign t_val  = (state_d == PM_WK_OSC) ? OSC_LD : SET_LD;

  pmc_timer #(.MAX_CYC(MAX_CYC)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= PM_ON;
    else     state_q <= state_d;
  end

  assert_idle_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_IDLE && wake_hit) |=> (state_q == PM_ON));

  assert_wake_no_req_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {PM_WK_OSC, PM_WK_PLL, PM_WK_SET}) |=>
      (state_q inside {PM_WK_OSC, PM_WK_PLL, PM_WK_SET, PM_ON}));

  assert_lock_loss_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_WK_SET && !pll_lock) |=> (state_q == PM_WK_PLL));

  assert_deep_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {PM_STOP, PM_SLEEP} && wake_hit) |=> (state_q == PM_WK_OSC));

endmodule

// File: rtl/pmc_outs.sv
module pmc_outs
  import pmc_pkg::*;
#(
  parameter int N_IP = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  pm_state_e       state_d,
  input  logic [N_IP-1:0] ip_mask_d,
  output logic [N_IP-1:0] ip_clk_en,
  output logic            cpu_clk_en,
  output logic            slow_clk_sel,
  output logic            osc_en,
  output logic            pll_en,
  output logic            logic_pwr_en,
  output logic [2:0]      mode_state
);

  pm_ctl_t nxt;
  assign nxt = pm_decode(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_clk_en    <= '1;
      cpu_clk_en   <= 1'b1;
      slow_clk_sel <= 1'b0;
      osc_en       <= 1'b1;
      pll_en       <= 1'b1;
      logic_pwr_en <= 1'b1;
      mode_state   <= 3'(PM_ON);
    end else begin
      ip_clk_en    <= nxt.clk_on ? ip_mask_d : '0;
      cpu_clk_en   <= nxt.cpu;
      slow_clk_sel <= nxt.slow;
      osc_en       <= nxt.osc;
      pll_en       <= nxt.pll;
      logic_pwr_en <= nxt.pwr;
      mode_state   <= 3'(state_d);
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_IP       = 8,
  parameter int N_WAKE     = 4,
  parameter int ADDR_W     = 1,
  parameter int OSC_CYC    = 4,
  parameter int SETTLE_CYC = 8,
  localparam int DATA_W    = (N_IP > N_WAKE) ? N_IP : N_WAKE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic              mode_req_vld,
  input  logic [2:0]        mode_req_code,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic              pll_lock,
  output logic [N_IP-1:0]   ip_clk_en,
  output logic              cpu_clk_en,
  output logic              slow_clk_sel,
  output logic              osc_en,
  output logic              pll_en,
  output logic              logic_pwr_en,
  output logic [2:0]        mode_state
);

  logic [N_IP-1:0]   ip_mask_q, ip_mask_d;
  logic [N_WAKE-1:0] wake_mask_q;
  pm_state_e         state_q, state_d;

  pmc_regs #(.N_IP(N_IP), .N_WAKE(N_WAKE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_wr_en),
    .wr_addr     (cfg_wr_addr),
    .wr_data     (cfg_wr_data),
    .ip_mask_q   (ip_mask_q),
    .ip_mask_d   (ip_mask_d),
    .wake_mask_q (wake_mask_q)
  );

  pmc_fsm #(.N_WAKE(N_WAKE), .OSC_CYC(OSC_CYC), .SETTLE_CYC(SETTLE_CYC)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (mode_req_vld),
    .req_code  (mode_req_code),
    .wake_evt  (wake_evt),
    .wake_mask (wake_mask_q),
    .pll_lock  (pll_lock),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  pmc_outs #(.N_IP(N_IP)) i_outs (
    .clk          (clk),
    .rst          (rst),
    .state_d      (state_d),
    .ip_mask_d    (ip_mask_d),
    .ip_clk_en    (ip_clk_en),
    .cpu_clk_en   (cpu_clk_en),
    .slow_clk_sel (slow_clk_sel),
    .osc_en       (osc_en),
    .pll_en       (pll_en),
    .logic_pwr_en (logic_pwr_en),
    .mode_state   (mode_state)
  );

  assert_sleep_off_R6: assert property (@(posedge clk) disable iff (rst)
    !logic_pwr_en |-> (!osc_en && !pll_en && !cpu_clk_en && ip_clk_en == '0));

  assert_osc_first_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> (osc_en && $past(osc_en)));

  assert_wake_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_state >= 3'd5) |-> (!cpu_clk_en && ip_clk_en == '0));

  assert_stop_clocks_R5: assert property (@(posedge clk) disable iff (rst)
    (!osc_en) |-> (!pll_en && !cpu_clk_en && ip_clk_en == '0));

  assert_state_track_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mode_state == 3'($past(state_d))));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

  localparam int N_IP = 8;
  localparam int N_WAKE = 4;
  localparam int OSC_CYC = 2;
  localparam int SETTLE_CYC = 3;

  // expected {cpu, slow, osc, pll, pwr} per mode, from the requirements
  localparam logic [4:0] C_ON  = 5'b10111;
  localparam logic [4:0] C_SLW = 5'b11111;
  localparam logic [4:0] C_IDL = 5'b00111;
  localparam logic [4:0] C_STP = 5'b00001;
  localparam logic [4:0] C_SLP = 5'b00000;
  localparam logic [4:0] C_WKO = 5'b00101;
  localparam logic [4:0] C_WKP = 5'b00111;

  typedef struct packed {
    logic       we;
    logic       wa;
    logic [7:0] wd;
    logic       rv;
    logic [2:0] rc;
    logic [3:0] wk;
    logic       lk;
    logic [2:0] es;
    logic [4:0] ec;
    logic [7:0] eip;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,1'b0,8'hA5,1'b0,3'd0,4'h0,1'b0,3'd0,C_ON ,8'hA5,4'd2},  // R2 clock mask
    '{1'b1,1'b1,8'h03,1'b0,3'd0,4'h0,1'b0,3'd0,C_ON ,8'hA5,4'd2},  // R2 wake mask
    '{1'b0,1'b0,8'h00,1'b1,3'd1,4'h0,1'b0,3'd1,C_SLW,8'hA5,4'd3},  // R3 slow
    '{1'b0,1'b0,8'h00,1'b1,3'd2,4'h0,1'b0,3'd2,C_IDL,8'hA5,4'd4},  // R4 idle
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h4,1'b0,3'd2,C_IDL,8'hA5,4'd8},  // R8 masked wake
    '{1'b0,1'b0,8'h00,1'b1,3'd0,4'h0,1'b0,3'd2,C_IDL,8'hA5,4'd7},  // R7 req in idle
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h1,1'b0,3'd0,C_ON ,8'hA5,4'd8},  // R8 idle exit
    '{1'b0,1'b0,8'h00,1'b1,3'd3,4'h0,1'b0,3'd3,C_STP,8'h00,4'd5},  // R5 stop
    '{1'b1,1'b0,8'h0F,1'b0,3'd0,4'h0,1'b0,3'd3,C_STP,8'h00,4'd5},  // R5 write in stop
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h2,1'b0,3'd5,C_WKO,8'h00,4'd9},  // R9 osc first
    '{1'b0,1'b0,8'h00,1'b1,3'd0,4'h0,1'b0,3'd5,C_WKO,8'h00,4'd7},  // R7 req in wake
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b0,3'd6,C_WKP,8'h00,4'd9},  // R9 pll on
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b0,3'd6,C_WKP,8'h00,4'd10}, // R10 wait lock
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10}, // R10 settle
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b0,3'd6,C_WKP,8'h00,4'd10}, // R10 lock lost
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd0,C_ON ,8'h0F,4'd10}, // R10 release
    '{1'b0,1'b0,8'h00,1'b1,3'd4,4'h0,1'b1,3'd4,C_SLP,8'h00,4'd6},  // R6 sleep
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h4,1'b1,3'd4,C_SLP,8'h00,4'd8},  // R8 masked in sleep
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h1,1'b1,3'd5,C_WKO,8'h00,4'd9},  // R9 supply back
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd5,C_WKO,8'h00,4'd9},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd6,C_WKP,8'h00,4'd9},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd7,C_WKP,8'h00,4'd10},
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h0,1'b1,3'd0,C_ON ,8'h0F,4'd10},
    '{1'b0,1'b0,8'h00,1'b1,3'd6,4'h0,1'b0,3'd0,C_ON ,8'h0F,4'd7},  // R7 bad code
    '{1'b0,1'b0,8'h00,1'b0,3'd0,4'h1,1'b0,3'd0,C_ON ,8'h0F,4'd8},  // R8 wake in on
    '{1'b0,1'b0,8'h00,1'b1,3'd1,4'h0,1'b0,3'd1,C_SLW,8'h0F,4'd3},  // R3 slow
    '{1'b0,1'b0,8'h00,1'b1,3'd0,4'h0,1'b0,3'd0,C_ON ,8'h0F,4'd3}   // R3 back to on
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wr_en;
  logic [0:0] cfg_wr_addr;
  logic [7:0] cfg_wr_data;
  logic       mode_req_vld;
  logic [2:0] mode_req_code;
  logic [3:0] wake_evt;
  logic       pll_lock;
  logic [7:0] ip_clk_en;
  logic       cpu_clk_en, slow_clk_sel, osc_en, pll_en, logic_pwr_en;
  logic [2:0] mode_state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_IP(N_IP), .N_WAKE(N_WAKE), .ADDR_W(1),
                  .OSC_CYC(OSC_CYC), .SETTLE_CYC(SETTLE_CYC)) i_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .mode_req_vld(mode_req_vld),
    .mode_req_code(mode_req_code), .wake_evt(wake_evt), .pll_lock(pll_lock),
    .ip_clk_en(ip_clk_en), .cpu_clk_en(cpu_clk_en), .slow_clk_sel(slow_clk_sel),
    .osc_en(osc_en), .pll_en(pll_en), .logic_pwr_en(logic_pwr_en),
    .mode_state(mode_state)
  );

  task automatic drive(input logic we, input logic wa, input logic [7:0] wd,
                       input logic rv, input logic [2:0] rc,
                       input logic [3:0] wk, input logic lk);
    cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd;
    mode_req_vld = rv; mode_req_code = rc; wake_evt = wk; pll_lock = lk;
  endtask

  task automatic check(input string rq, input logic [2:0] es,
                       input logic [4:0] ec, input logic [7:0] eip);
    logic [4:0] act;
    act = {cpu_clk_en, slow_clk_sel, osc_en, pll_en, logic_pwr_en};
    checks++;
    if (mode_state !== es || act !== ec || ip_clk_en !== eip) begin
      failures++;
      $display("FAIL %s: state=%0d ctl=%b ip=%h expected state=%0d ctl=%b ip=%h",
               rq, mode_state, act, ip_clk_en, es, ec, eip);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'h0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 3'd0, C_ON, 8'hFF);            // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check("R1", 3'd0, C_ON, 8'hFF);            // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].rv, VEC[i].rc, VEC[i].wk, VEC[i].lk);
      @(negedge clk);
      check($sformatf("R%0d row%0d", VEC[i].rq, i), VEC[i].es, VEC[i].ec, VEC[i].eip);
    end

    // R1: reset in the middle of a wake sequence returns to ON defaults
    drive(1'b0, 1'b0, 8'h00, 1'b1, 3'd3, 4'h0, 1'b0);
    @(negedge clk);
    check("R5 stop", 3'd3, C_STP, 8'h00);
    drive(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'h1, 1'b0);
    @(negedge clk);
    check("R9 wake", 3'd5, C_WKO, 8'h00);
    drive(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'h0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-wake", 3'd0, C_ON, 8'hFF);

    // R1: wake mask cleared by reset, so IDLE is not left
    drive(1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 4'h0, 1'b0);
    @(negedge clk);
    check("R4 idle", 3'd2, C_IDL, 8'hFF);
    drive(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'hF, 1'b0);
    @(negedge clk);
    check("R1 mask cleared", 3'd2, C_IDL, 8'hFF);

    // R2: unmapped address ignored is not reachable with ADDR_W=1; write mask in IDLE
    drive(1'b1, 1'b1, 8'h08, 1'b0, 3'd0, 4'h0, 1'b0);
    @(negedge clk);
    check("R8 mask write only", 3'd2, C_IDL, 8'hFF);
    drive(1'b1, 1'b0, 8'h3C, 1'b0, 3'd0, 4'h0, 1'b0);
    @(negedge clk);
    check("R2 mask in idle", 3'd2, C_IDL, 8'h3C);
    // R8: request and wake in the same cycle: wake wins, request dropped
    drive(1'b0, 1'b0, 8'h00, 1'b1, 3'd4, 4'h8, 1'b0);
    @(negedge clk);
    check("R8 wake with req", 3'd0, C_ON, 8'h3C);
    drive(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'h0, 1'b0);
    @(negedge clk);
    check("R7 no late req", 3'd0, C_ON, 8'h3C);

    finish_run();
  end

endmodule